// File: doc/BRIEF.md
# Dual-Channel Phase-Shifted PWM Generator

This block drives two pulse-width-modulated outputs from one system clock. One shared period counter sets the PWM frequency. Both channels compare against a single duty value. The second channel sees the counter shifted by a programmable phase offset, so its pulse is displaced in time from the first channel's pulse.

An external controller changes the settings through a small write port: an address, a data word, a write strobe and a commit strobe. Writes only change a pending copy of the settings. A commit takes a snapshot of all three pending values at once. The snapshot becomes active only when the counter wraps. Because of this, a period is never cut short, and a request for 0% or 100% duty takes hold only at a period boundary.

Top module: `dual_pwm_core`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) drives both outputs low on the following cycle and loads period 100, duty 50, phase 0 into both the pending and the active settings.
- R2: The counter runs from 0 to PERIOD-1 and then wraps to 0. `pwm_a` is high in the cycle after a counter value that is less than DUTY.
- R3: `pwm_b` is high in the cycle after a counter value c for which (c + PHASE) mod PERIOD is less than DUTY.
- R4: An active DUTY of 0 holds both outputs low for the whole period.
- R5: An active DUTY greater than or equal to PERIOD holds both outputs high for the whole period.
- R6: Writes without a commit do not change the outputs.
- R7: A commit's values become active together at the first counter wrap after the commit cycle, and never in the middle of a period.
- R8: A commit captures the pending values as they stood before that cycle. A write in the same cycle as the commit, or after it, waits for a later commit.
- R9: A committed PERIOD of 0 behaves as a PERIOD of 1.
- R10: A committed PHASE at or above PERIOD is reduced modulo PERIOD.
- R11: Address map: 0 selects period, 1 selects duty, 2 selects phase. Writes to address 3 are ignored.
- R12: A commit in the same cycle as a wrap does not apply at that wrap. It applies at the following wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_addr | input | 2 | Setting select for a write |
| cfg_data | input | W (16) | Write data |
| cfg_wr | input | 1 | Write strobe into the pending settings |
| cfg_commit | input | 1 | Snapshot the pending settings for the next wrap |
| pwm_a | output | 1 | Reference PWM output |
| pwm_b | output | 1 | Phase-shifted PWM output |

## Verification
The bench times commits to land mid-period, in the exact cycle of a wrap, and in the same cycle as a write. A design that applied settings at once would glitch the current period. A design that applied a commit at a coincident wrap would switch one period early. A design that captured same-cycle writes would take the wrong duty. Duty values of 0, PERIOD and above PERIOD are used to catch off-by-one compares that leave a one-cycle sliver. A zero period and a phase several times the period are used to catch a missing clamp or missing modulo reduction, which would make the counter run away or make channel B never fire.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;
    typedef enum logic [1:0] {
        SEL_PERIOD = 2'd0,
        SEL_DUTY   = 2'd1,
        SEL_PHASE  = 2'd2,
        SEL_NONE   = 2'd3
    } cfg_sel_e;
endpackage

// File: rtl/pwm_cfg_shadow.sv
module pwm_cfg_shadow #(
    parameter int W           = 16,
    parameter int DEF_PERIOD  = 100,
    parameter int DEF_DUTY    = 50,
    parameter int DEF_PHASE   = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         wr_en,
    input  logic         commit,
    input  logic         apply,
    output logic [W-1:0] period_o,
    output logic [W-1:0] duty_o,
    output logic [W-1:0] phase_o
);
    import pwm2_pkg::*;

    localparam logic [W-1:0] RST_PER = (DEF_PERIOD < 1) ? W'(1) : W'(DEF_PERIOD);
    localparam logic [W-1:0] RST_DUT = W'(DEF_DUTY);
    localparam logic [W-1:0] RST_PHS = W'(DEF_PHASE % ((DEF_PERIOD < 1) ? 1 : DEF_PERIOD));

    typedef struct packed {
        logic [W-1:0] per;
        logic [W-1:0] dut;
        logic [W-1:0] phs;
    } cfg_t;

    typedef struct packed {
        cfg_t pend;
        cfg_t stg;
        logic stg_vld;
        cfg_t act;
    } shadow_t;

    shadow_t st_d, st_q;
    logic [W-1:0] snap_per;

    always_comb begin
        st_d     = st_q;
        snap_per = (st_q.pend.per == '0) ? W'(1) : st_q.pend.per;
        if (apply && st_q.stg_vld) begin
            st_d.act     = st_q.stg;
            st_d.stg_vld = 1'b0;
        end
        if (commit) begin
            st_d.stg.per = snap_per;
            st_d.stg.dut = st_q.pend.dut;
            st_d.stg.phs = st_q.pend.phs % snap_per;
            st_d.stg_vld = 1'b1;
        end
        if (wr_en) begin
            unique case (cfg_sel_e'(wr_sel))
                SEL_PERIOD: st_d.pend.per = wr_data;
                SEL_DUTY:   st_d.pend.dut = wr_data;
                SEL_PHASE:  st_d.pend.phs = wr_data;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.pend    <= '{per: RST_PER, dut: RST_DUT, phs: RST_PHS};
            st_q.stg     <= '{per: RST_PER, dut: RST_DUT, phs: RST_PHS};
            st_q.stg_vld <= 1'b0;
            st_q.act     <= '{per: RST_PER, dut: RST_DUT, phs: RST_PHS};
        end else begin
            st_q <= st_d;
        end
    end

    assign period_o = st_q.act.per;
    assign duty_o   = st_q.act.dut;
    assign phase_o  = st_q.act.phs;
endmodule

// File: rtl/pwm_period_counter.sv
module pwm_period_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] period,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } ctr_t;

    ctr_t ct_d, ct_q;
    logic last;

    always_comb begin
        ct_d = ct_q;
        last = ({1'b0, ct_q.cnt} + 1'b1) >= {1'b0, period};
        if (last) begin
            ct_d.cnt = '0;
        end else begin
            ct_d.cnt = ct_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ct_q.cnt <= '0;
        end else begin
            ct_q <= ct_d;
        end
    end

    assign cnt_o  = ct_q.cnt;
    assign wrap_o = last;
endmodule

// File: rtl/pwm_channel_out.sv
module pwm_channel_out #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] offset,
    input  logic [W-1:0] period,
    input  logic [W-1:0] duty,
    output logic         pwm_o
);
    typedef struct packed {
        logic lvl;
    } ch_t;

    ch_t ch_d, ch_q;
    logic [W:0]   sum;
    logic [W-1:0] local_cnt;

    always_comb begin
        ch_d = ch_q;
        sum  = {1'b0, cnt} + {1'b0, offset};
        if (sum >= {1'b0, period}) begin
            local_cnt = W'(sum - {1'b0, period});
        end else begin
            local_cnt = sum[W-1:0];
        end
        ch_d.lvl = (local_cnt < duty);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ch_q.lvl <= 1'b0;
        end else begin
            ch_q <= ch_d;
        end
    end

    assign pwm_o = ch_q.lvl;
endmodule

// File: rtl/dual_pwm_core.sv
module dual_pwm_core #(
    parameter int W          = 16,
    parameter int DEF_PERIOD = 100,
    parameter int DEF_DUTY   = 50,
    parameter int DEF_PHASE  = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   cfg_addr,
    input  logic [W-1:0] cfg_data,
    input  logic         cfg_wr,
    input  logic         cfg_commit,
    output logic         pwm_a,
    output logic         pwm_b
);
    localparam int NUM_CH = 2;

    logic [W-1:0] act_period;
    logic [W-1:0] act_duty;
    logic [W-1:0] act_phase;
    logic [W-1:0] cnt_val;
    logic         cnt_wrap;
    logic [W-1:0] ch_offset [NUM_CH];
    logic         ch_level  [NUM_CH];

    pwm_cfg_shadow #(
        .W(W), .DEF_PERIOD(DEF_PERIOD), .DEF_DUTY(DEF_DUTY), .DEF_PHASE(DEF_PHASE)
    ) u_shadow (
        .clk(clk), .rst(rst),
        .wr_sel(cfg_addr), .wr_data(cfg_data), .wr_en(cfg_wr),
        .commit(cfg_commit), .apply(cnt_wrap),
        .period_o(act_period), .duty_o(act_duty), .phase_o(act_phase)
    );

    pwm_period_counter #(.W(W)) u_counter (
        .clk(clk), .rst(rst), .period(act_period),
        .cnt_o(cnt_val), .wrap_o(cnt_wrap)
    );

    assign ch_offset[0] = '0;
    assign ch_offset[1] = act_phase;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_channel_out #(.W(W)) u_ch (
            .clk(clk), .rst(rst), .cnt(cnt_val), .offset(ch_offset[g]),
            .period(act_period), .duty(act_duty), .pwm_o(ch_level[g])
        );
    end

    assign pwm_a = ch_level[0];
    assign pwm_b = ch_level[1];
endmodule

// File: rtl/dual_pwm_core_chk.sv
module dual_pwm_core_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         wrap,
    input logic [W-1:0] cnt,
    input logic [W-1:0] period,
    input logic [W-1:0] duty,
    input logic [W-1:0] phase,
    input logic         pwm_a,
    input logic         pwm_b
);
    AST_RESET_LOW: assert property (@(posedge clk) rst |=> (!pwm_a && !pwm_b)); // R1
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst) cnt < period); // R2
    AST_HOLD_MID_PERIOD: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> ($stable(period) && $stable(duty) && $stable(phase))); // R7
    AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (rst)
        (duty == '0) |=> (!pwm_a && !pwm_b)); // R4
    AST_FULL_DUTY_HIGH: assert property (@(posedge clk) disable iff (rst)
        (duty >= period) |=> (pwm_a && pwm_b)); // R5
    AST_PERIOD_NONZERO: assert property (@(posedge clk) disable iff (rst) period != '0); // R9
    AST_PHASE_REDUCED: assert property (@(posedge clk) disable iff (rst) phase < period); // R10
endmodule

bind dual_pwm_core dual_pwm_core_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .wrap(cnt_wrap), .cnt(cnt_val),
    .period(act_period), .duty(act_duty), .phase(act_phase),
    .pwm_a(pwm_a), .pwm_b(pwm_b)
);

// File: tb/test_dual_pwm_core.sv
module test_dual_pwm_core;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   cfg_addr = '0;
    logic [W-1:0] cfg_data = '0;
    logic         cfg_wr = 1'b0;
    logic         cfg_commit = 1'b0;
    logic         pwm_a, pwm_b;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;
    string cur_req = "R1";

    bit exp_a_q[$];
    bit exp_b_q[$];

    // reference model state
    int m_cnt, m_per, m_dut, m_phs;
    int p_per, p_dut, p_phs;
    int s_per, s_dut, s_phs;
    bit s_vld;

    always #5 clk = ~clk;

    dual_pwm_core i_dual_pwm_core (
        .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .cfg_wr(cfg_wr), .cfg_commit(cfg_commit), .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    // model: predicts outputs of the next cycle, then advances
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            exp_a_q.push_back(1'b0);
            exp_b_q.push_back(1'b0);
            m_cnt = 0; m_per = 100; m_dut = 50; m_phs = 0;
            p_per = 100; p_dut = 50; p_phs = 0;
            s_per = 100; s_dut = 50; s_phs = 0; s_vld = 0;
        end else begin
            bit wrap;
            exp_a_q.push_back(m_cnt < m_dut);
            exp_b_q.push_back(((m_cnt + m_phs) % m_per) < m_dut);
            wrap = (m_cnt == m_per - 1);
            if (wrap && s_vld) begin
                m_per = s_per; m_dut = s_dut; m_phs = s_phs; s_vld = 0;
            end
            if (cfg_commit) begin
                s_per = (p_per == 0) ? 1 : p_per;
                s_dut = p_dut;
                s_phs = p_phs % s_per;
                s_vld = 1;
            end
            if (cfg_wr) begin
                case (cfg_addr)
                    2'd0: p_per = int'(cfg_data);
                    2'd1: p_dut = int'(cfg_data);
                    2'd2: p_phs = int'(cfg_data);
                    default: ;
                endcase
            end
            m_cnt = wrap ? 0 : m_cnt + 1;
        end
    end

    // monitor: compare away from the active edge
    always @(negedge clk) begin
        if (exp_a_q.size() > 0) begin
            bit ea, eb;
            ea = exp_a_q.pop_front();
            eb = exp_b_q.pop_front();
            checks++;
            if (pwm_a !== ea) begin
                errors++;
                $display("FAIL %s pwm_a actual %b expected %b at cycle %0d", cur_req, pwm_a, ea, cycles);
            end
            checks++;
            if (pwm_b !== eb) begin
                errors++;
                $display("FAIL %s pwm_b actual %b expected %b at cycle %0d", cur_req, pwm_b, eb, cycles);
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        @(negedge clk);
        cfg_addr = a; cfg_data = W'(d); cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic commit();
        @(negedge clk);
        cfg_commit = 1'b1;
        @(negedge clk);
        cfg_commit = 1'b0;
    endtask

    task automatic wait_wrap_cycle();
        @(negedge clk);
        while (m_cnt != m_per - 1) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        wait (cycles > 200000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        cur_req = "R1";
        idle(4);
        @(negedge clk); rst = 1'b0;
        cur_req = "R2 R3";
        idle(230);

        cur_req = "R6";
        wr(2'd0, 20); wr(2'd1, 5);
        idle(150);

        cur_req = "R11";
        wr(2'd3, 7);
        wr(2'd2, 7);
        idle(10);

        cur_req = "R7";
        commit();
        idle(120);

        cur_req = "R8";
        commit();
        wr(2'd1, 12);
        idle(70);
        @(negedge clk);
        cfg_addr = 2'd1; cfg_data = W'(3); cfg_wr = 1'b1; cfg_commit = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_commit = 1'b0;
        idle(60);
        commit();
        idle(60);

        cur_req = "R4";
        wr(2'd1, 0); commit();
        idle(70);

        cur_req = "R5";
        wr(2'd1, 20); commit();
        idle(50);
        wr(2'd1, 25); commit();
        idle(50);

        cur_req = "R9";
        wr(2'd0, 0); wr(2'd1, 1); wr(2'd2, 0); commit();
        idle(20);
        wr(2'd0, 3); commit();
        idle(20);

        cur_req = "R10";
        wr(2'd0, 10); wr(2'd1, 4); wr(2'd2, 27); commit();
        idle(60);

        cur_req = "R12";
        wr(2'd0, 16); wr(2'd1, 9); wr(2'd2, 5);
        wait_wrap_cycle();
        cfg_commit = 1'b1;
        @(negedge clk);
        cfg_commit = 1'b0;
        idle(60);

        cur_req = "R7";
        wr(2'd0, 40); wr(2'd1, 30); wr(2'd2, 13);
        idle(3);
        commit();
        idle(100);

        cur_req = "R1";
        @(negedge clk); rst = 1'b1;
        idle(3);
        @(negedge clk); rst = 1'b0;
        idle(210);

        idle(2);
        finish_run();
    end
endmodule